// File: doc/BRIEF.md
# Snooze Low-Power Mode Sequencer

This block sequences a data-retaining sleep state for a synchronous memory. A free-running, asynchronous snooze request enters through a synchronizer. A sustained request must last for a standby window before the block commits to sleep. Dropping the request starts a recovery window, and normal access resumes only when that window ends. The block sits in front of the access logic. It forwards the ordinary control inputs and the address strobes when the device is fully awake. It forces them to zero otherwise, so that only the snooze request is observed while the device sleeps or changes state.

The two windows are counted in clock cycles. They are derived from a time budget (default 100 ns) and the clock period, both given in picoseconds. The standby window is rounded down, because entry must take no longer than the budget. The recovery window is rounded up, because wake-up must take at least the budget. Status outputs give the current state and separate flags for sleep, input gating and strobe hold-off.

Top module: `snz_sequencer`

## Requirements
- R1: After a synchronous active-low reset, even one applied while asleep, the state code is 00 (awake), all flags are low, and control inputs and strobes pass through unchanged.
- R2: The snooze input passes through a two-stage synchronizer. A change driven before clock edge k first changes the state at edge k+2, and not earlier.
- R3: In the entering state (code 01), a held snooze request leads to the asleep state (code 10) after exactly ENTRY_CYC cycles. ENTRY_CYC = max(1, floor(WINDOW_PS/CLK_PERIOD_PS)), which is 10 by default.
- R4: A synchronized snooze low while in the entering state returns the block to awake (code 00) on the next edge.
- R5: While asleep, `ctrl_out` is all zeros whatever `ctrl_in` is. Changes on `ctrl_in` and `strb_in` do not move the state away from asleep.
- R6: A synchronized snooze low while asleep leads to the recovering state (code 11). After exactly REC_CYC cycles there, the block returns to awake. REC_CYC = max(1, ceil(WINDOW_PS/CLK_PERIOD_PS)), which is 10 by default.
- R7: `strb_out` is all zeros in the entering, asleep and recovering states, and equals `strb_in` when awake. `strobe_hold_o` and `input_gate_o` are high exactly when the state is not awake.
- R8: A synchronized snooze high while recovering restarts the entry sequence. The state goes to entering (code 01) on the next edge, and the full ENTRY_CYC window applies again.
- R9: `asleep_o` is high only in state code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snooze_async | input | 1 | Asynchronous sleep request, high to sleep |
| ctrl_in | input | CTRL_W | Control inputs toward the access logic |
| strb_in | input | STRB_W | Address strobes toward the access logic |
| ctrl_out | output | CTRL_W | Gated control inputs |
| strb_out | output | STRB_W | Gated address strobes |
| state_code | output | 2 | 00 awake, 01 entering, 10 asleep, 11 recovering |
| asleep_o | output | 1 | High in the asleep state |
| input_gate_o | output | 1 | High while control inputs are blocked |
| strobe_hold_o | output | 1 | High while strobes are held off |

## Verification
The hardest case to reach is a snooze reversal inside a timed window: the request must fall during entry, or rise during recovery. Because of the synchronizer latency, the edge must be placed so that it is seen before the counter expires. The stimulus drives snooze on a falling clock edge and counts whole cycles from that point. It reverses the request three cycles into the window, which is well short of either window length. The bench then checks the state one cycle before and one cycle after the expected transition.

// File: rtl/snz_pkg.sv
// Shared types for the snooze sequencer.
// Assumes: the state encoding is visible on the status port and is fixed.
package snz_pkg;
    typedef enum logic [1:0] {
        SNZ_AWAKE      = 2'b00,
        SNZ_ENTERING   = 2'b01,
        SNZ_ASLEEP     = 2'b10,
        SNZ_RECOVERING = 2'b11
    } snz_state_e;
endpackage

// File: rtl/snz_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
// Assumes: the input is a slow level, so bus skew does not matter; reset clears the chain.
module snz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/snz_window_cnt.sv
// Cycle counter for the timed windows.
// Assumes: the sequencer clears it on every state change and while idle.
module snz_window_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    // Count the cycles spent in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else               count <= count + 1'b1;
    end
endmodule

// File: rtl/snz_gate.sv
// Forces a bus to zero while a block signal is high.
// Assumes: gating is purely combinational and adds no latency.
module snz_gate #(
    parameter int W = 8
) (
    input  logic         block,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[i] & ~block;
    end
endmodule

// File: rtl/snz_fsm.sv
// State sequencer for entering, staying in and leaving the sleep state.
// Assumes: zz_s is already synchronized; count comes from a counter that
// this module clears on every state change.
module snz_fsm
    import snz_pkg::*;
#(
    parameter int ENTRY_CYC = 10,
    parameter int REC_CYC   = 10,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zz_s,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output snz_state_e       state_q
);
    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);

    snz_state_e state_d;

    // Choose the next state from the request level and the window count.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNZ_AWAKE:      if (zz_s) state_d = SNZ_ENTERING;
            SNZ_ENTERING:   if (!zz_s) state_d = SNZ_AWAKE;
                            else if (count == ENTRY_LAST) state_d = SNZ_ASLEEP;
            SNZ_ASLEEP:     if (!zz_s) state_d = SNZ_RECOVERING;
            SNZ_RECOVERING: if (zz_s) state_d = SNZ_ENTERING;
                            else if (count == REC_LAST) state_d = SNZ_AWAKE;
            default:        state_d = SNZ_AWAKE;
        endcase
    end

    // Restart the window count on each change of state and in the untimed states.
    always_comb begin
        cnt_clr = (state_d != state_q) || (state_q == SNZ_AWAKE) || (state_q == SNZ_ASLEEP);
    end

    // Register the state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SNZ_AWAKE;
        else        state_q <= state_d;
    end

    assert_asleep_via_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNZ_ASLEEP && $past(state_q) != SNZ_ASLEEP) |-> $past(state_q) == SNZ_ENTERING);
    assert_abort_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNZ_ENTERING && !zz_s) |=> state_q == SNZ_AWAKE);
    assert_sleep_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNZ_ASLEEP && zz_s) |=> state_q == SNZ_ASLEEP);
    assert_wake_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNZ_ASLEEP && !zz_s) |=> state_q == SNZ_RECOVERING);
    assert_reenter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNZ_RECOVERING && zz_s) |=> state_q == SNZ_ENTERING);
endmodule

// File: rtl/snz_sequencer.sv
// Top of the snooze sequencer: synchronizes the sleep request, times the
// standby and recovery windows, and gates control inputs and strobes.
// Assumes: the CLK_PERIOD_PS and WINDOW_PS parameters match the real clock.
module snz_sequencer
    import snz_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int WINDOW_PS     = 100000,
    parameter int CTRL_W        = 8,
    parameter int STRB_W        = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snooze_async,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic [STRB_W-1:0] strb_in,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic [STRB_W-1:0] strb_out,
    output logic [1:0]        state_code,
    output logic              asleep_o,
    output logic              input_gate_o,
    output logic              strobe_hold_o
);
    localparam int ENTRY_RAW = WINDOW_PS / CLK_PERIOD_PS;
    localparam int REC_RAW   = (WINDOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int ENTRY_CYC = (ENTRY_RAW < 1) ? 1 : ENTRY_RAW;
    localparam int REC_CYC   = (REC_RAW < 1) ? 1 : REC_RAW;
    localparam int MAX_CYC   = (ENTRY_CYC > REC_CYC) ? ENTRY_CYC : REC_CYC;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             zz_s;
    logic             cnt_clr;
    logic [CNT_W-1:0] count;
    snz_state_e       state_q;
    logic             not_awake;

    snz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(snooze_async), .q_sync(zz_s)
    );

    snz_window_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .count(count)
    );

    snz_fsm #(.ENTRY_CYC(ENTRY_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .zz_s(zz_s), .count(count),
        .cnt_clr(cnt_clr), .state_q(state_q)
    );

    // Decode the status flags from the registered state.
    always_comb begin
        not_awake     = (state_q != SNZ_AWAKE);
        state_code    = state_q;
        asleep_o      = (state_q == SNZ_ASLEEP);
        input_gate_o  = not_awake;
        strobe_hold_o = not_awake;
    end

    snz_gate #(.W(CTRL_W)) u_ctrl_gate (.block(input_gate_o),  .din(ctrl_in), .dout(ctrl_out));
    snz_gate #(.W(STRB_W)) u_strb_gate (.block(strobe_hold_o), .din(strb_in), .dout(strb_out));

    assert_ctrl_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 2'b10) |-> ctrl_out == '0);
    assert_strb_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code != 2'b00) |-> strb_out == '0);
    assert_asleep_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |-> (state_code == 2'b10));
endmodule

// File: tb/snz_sequencer_test.sv
module snz_sequencer_test;
    localparam int TCLK  = 10;
    localparam int ENTRY = 10;   // floor(100000/10000)
    localparam int REC   = 10;   // ceil(100000/10000)
    localparam int NVEC  = 6;
    localparam logic [9:0] VEC [NVEC] = '{10'h3FF, 10'h000, 10'h2A5, 10'h15A, 10'h0F1, 10'h301};

    logic       clk = 0;
    logic       rst_n = 0;
    logic       snooze_async = 0;
    logic [7:0] ctrl_in = '0;
    logic [1:0] strb_in = '0;
    logic [7:0] ctrl_out;
    logic [1:0] strb_out;
    logic [1:0] state_code;
    logic       asleep_o, input_gate_o, strobe_hold_o;
    int n_tests = 0;
    int n_fail  = 0;

    always #(TCLK/2) clk = ~clk;

    snz_sequencer uut (
        .clk(clk), .rst_n(rst_n), .snooze_async(snooze_async),
        .ctrl_in(ctrl_in), .strb_in(strb_in), .ctrl_out(ctrl_out), .strb_out(strb_out),
        .state_code(state_code), .asleep_o(asleep_o),
        .input_gate_o(input_gate_o), .strobe_hold_o(strobe_hold_o)
    );

    task automatic step(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic walk(string tag, bit awake);
        for (int i = 0; i < NVEC; i++) begin
            {ctrl_in, strb_in} = VEC[i];
            #1;
            chk(tag, {22'd0, ctrl_out, strb_out}, awake ? {22'd0, VEC[i]} : 32'd0);
            chk(tag, {30'd0, state_code}, awake ? 32'd0 : 32'd2);
            step(1);
            chk(tag, {30'd0, state_code}, awake ? 32'd0 : 32'd2);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1;
        // R1: reset state
        chk("R1 state", {30'd0, state_code}, 0);
        chk("R1 flags", {29'd0, asleep_o, input_gate_o, strobe_hold_o}, 0);
        walk("R1 pass-through awake", 1'b1);

        // R2/R3: timed entry
        strb_in = 2'b11; ctrl_in = 8'hA5;
        snooze_async = 1;
        step(2); chk("R2 not before sync", {30'd0, state_code}, 0);
        step(1); chk("R2 entering", {30'd0, state_code}, 1);
        chk("R7 strobe held entering", {30'd0, strb_out}, 0);
        chk("R7 flags entering", {30'd0, input_gate_o, strobe_hold_o}, 3);
        step(ENTRY - 1); chk("R3 still entering", {30'd0, state_code}, 1);
        step(1); chk("R3 asleep", {30'd0, state_code}, 2);
        chk("R9 asleep flag", {31'd0, asleep_o}, 1);
        // R5: inputs ignored while asleep
        walk("R5 gated asleep", 1'b0);

        // R6: recovery window
        strb_in = 2'b11;
        snooze_async = 0;
        step(2); chk("R6 still asleep", {30'd0, state_code}, 2);
        step(1); chk("R6 recovering", {30'd0, state_code}, 3);
        chk("R9 no asleep flag recovering", {31'd0, asleep_o}, 0);
        chk("R7 strobe held recovering", {30'd0, strb_out}, 0);
        step(REC - 1); chk("R6 still recovering", {30'd0, state_code}, 3);
        chk("R7 strobe held last cycle", {30'd0, strb_out}, 0);
        step(1); chk("R6 awake", {30'd0, state_code}, 0);
        chk("R7 strobe passes awake", {30'd0, strb_out}, 3);

        // R4: abort entry
        snooze_async = 1;
        step(3); chk("R4 entering", {30'd0, state_code}, 1);
        snooze_async = 0;
        step(2); chk("R4 still entering", {30'd0, state_code}, 1);
        step(1); chk("R4 back awake", {30'd0, state_code}, 0);

        // R8: re-entry from recovery, full window again
        snooze_async = 1;
        step(3 + ENTRY); chk("R8 asleep first", {30'd0, state_code}, 2);
        snooze_async = 0;
        step(3); chk("R8 recovering", {30'd0, state_code}, 3);
        snooze_async = 1;
        step(2); chk("R8 still recovering", {30'd0, state_code}, 3);
        step(1); chk("R8 entering again", {30'd0, state_code}, 1);
        step(ENTRY - 1); chk("R8 full window", {30'd0, state_code}, 1);
        step(1); chk("R8 asleep again", {30'd0, state_code}, 2);

        // R1: reset while asleep
        rst_n = 0;
        step(1);
        rst_n = 1;
        chk("R1 reset from asleep", {30'd0, state_code}, 0);
        chk("R1 strobes pass after reset", {30'd0, strb_out}, {30'd0, strb_in});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule